// File: doc/BRIEF.md
# Serial Conversion-Word Readout Port

This block is the converter-side end of a four-wire serial readout. A conversion result arrives as a parallel word with a one-cycle load strobe and is stored in an output register. Each time that register takes a new value, an active-low ready line drops for a fixed number of system clocks so the host knows a fresh word waits. The host then pulls its active-low select line low and reads the word one bit at a time, most significant bit first, on a serial clock that runs all the time.

The serial clock and the select line come from the host and are asynchronous to the system clock. Both pass through two-flop synchronizers, and their edges are found from the synchronized samples. Because the serial clock never stops, only the select line marks the start and the end of a read. The first bit is on the data pin as soon as the select low is seen, and each later bit follows a falling serial clock edge. A read longer than the word width gets zeros for the extra bits, so the host can clock a byte-aligned 24-bit read. A new word that arrives during a read is held back until the select line goes high again, so a read in progress always returns one consistent word.

Top module: `ser_readout_port`

## Requirements
- R1: After reset, rdy_n is 1, sdo_oe is 0 and the output register holds all zeros, so a read returns only 0 bits.
- R2: A load_strobe pulse while the synchronized select is high writes load_data into the 20-bit output register, and the next read returns that word.
- R3: Each write of the output register drives rdy_n low for exactly PULSE_W system clocks (default 4), after which it returns to 1. With no write, rdy_n stays 1.
- R4: Within 3 system clocks after cs_n_in falls, and before any falling serial clock edge, sdo_oe is 1 and sdo shows bit 19 of the output register.
- R5: Each falling edge of sclk_in seen while the select is low moves sdo to the next lower bit. Bit k of the read (k = 0 first) is word bit 19-k. Between falling edges sdo does not change.
- R6: Serial clock falling edges after the 20th bit of a read make sdo 0 for every extra bit.
- R7: While the synchronized select is high, sdo_oe is 0 (data pin in high impedance).
- R8: A load_strobe during a read changes neither the bits of that read nor rdy_n. The word is kept pending and written to the output register once the select returns high, and that write gives the usual rdy_n pulse.
- R9: A read cut short by raising cs_n_in does not carry over. The next falling edge of cs_n_in starts again at bit 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_data | input | 20 | Parallel conversion word |
| load_strobe | input | 1 | One-cycle strobe that writes load_data |
| sclk_in | input | 1 | Free-running serial clock from the host, asynchronous |
| cs_n_in | input | 1 | Active-low select from the host, asynchronous |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Output enable for the data pin (0 means high impedance) |
| rdy_n | output | 1 | Active-low ready pulse after each register write |

## Verification
Random 20-bit words are read with both 20-clock and 24-clock reads. Wrong bit order or a shift on the wrong edge shows up against the expected bit sequence, and leftover data after the 20th bit fails the zero-padding checks. Directed words (all ones, alternating bits, bit 19 and bit 0 alone) separate fill-value faults from ordering faults. A read cut off after six bits and then repeated tests the restart at bit 19. A strobe placed in the middle of a read tests that the word is held back, and the count of rdy_n low cycles after the select rises tests when the pending word is written.

// File: rtl/ser_readout_pkg.sv
package ser_readout_pkg;

    localparam int unsigned DEF_WORD_W   = 20;
    localparam int unsigned DEF_PULSE_W  = 4;
    localparam int unsigned DEF_SYNC_LEN = 2;

endpackage

// File: rtl/sro_sync.sv
module sro_sync #(
    parameter int unsigned STAGES  = ser_readout_pkg::DEF_SYNC_LEN,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
        level      = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sro_drdy_timer.sv
module sro_drdy_timer #(
    parameter int unsigned PULSE_W = ser_readout_pkg::DEF_PULSE_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic rdy_n
);

    localparam int unsigned CNT_W = $clog2(PULSE_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trigger) begin
            st_d.remain = CNT_W'(PULSE_W);
        end else if (st_q.remain != '0) begin
            st_d.remain = st_q.remain - 1'b1;
        end
        rdy_n = (st_q.remain == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.remain <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a write always pulls the ready line low on the next cycle
    assert_pulse_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> !rdy_n);

    // R3: an idle ready line stays high until a write arrives
    assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_n && !trigger) |=> rdy_n);

endmodule

// File: rtl/sro_shifter.sv
module sro_shifter #(
    parameter int unsigned WORD_W = ser_readout_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              cs_lvl,
    input  logic              sclk_lvl,
    output logic              sdo,
    output logic              sdo_oe
);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic              cs_prev;
        logic              sclk_prev;
    } shf_st_t;

    shf_st_t st_d, st_q;
    logic    cs_fall;
    logic    sclk_fall;
    logic    shift_en;

    always_comb begin
        st_d           = st_q;
        cs_fall        = st_q.cs_prev & ~cs_lvl;
        sclk_fall      = st_q.sclk_prev & ~sclk_lvl;
        shift_en       = sclk_fall & ~cs_lvl & ~cs_fall;
        st_d.cs_prev   = cs_lvl;
        st_d.sclk_prev = sclk_lvl;
        if (cs_lvl) begin
            st_d.shreg = word;
        end else if (shift_en) begin
            st_d.shreg = {st_q.shreg[WORD_W-2:0], 1'b0};
        end
        sdo_oe = ~cs_lvl;
        sdo    = sdo_oe & st_q.shreg[WORD_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shreg     <= '0;
            st_q.cs_prev   <= 1'b1;
            st_q.sclk_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4 and R9: on a select fall the top bit is the one held just before
    assert_restart_msb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |-> (st_q.shreg[WORD_W-1] == $past(word[WORD_W-1])));

    // R5: during a read the shift register moves only on a serial falling edge
    assert_hold_between_edges_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_lvl && !shift_en) |=> $stable(st_q.shreg));

    // R6: every shift brings a zero in at the bottom
    assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (st_q.shreg[0] == 1'b0));

endmodule

// File: rtl/ser_readout_port.sv
module ser_readout_port #(
    parameter int unsigned WORD_W   = ser_readout_pkg::DEF_WORD_W,
    parameter int unsigned PULSE_W  = ser_readout_pkg::DEF_PULSE_W,
    parameter int unsigned SYNC_LEN = ser_readout_pkg::DEF_SYNC_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] load_data,
    input  logic              load_strobe,
    input  logic              sclk_in,
    input  logic              cs_n_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              rdy_n
);

    typedef struct packed {
        logic [WORD_W-1:0] dor;
        logic [WORD_W-1:0] pend;
        logic              pend_v;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    cs_lvl;
    logic    sclk_lvl;
    logic    upd;

    sro_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) i_cs_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cs_n_in),
        .level    (cs_lvl)
    );

    sro_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) i_sclk_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk_in),
        .level    (sclk_lvl)
    );

    always_comb begin
        st_d = st_q;
        upd  = 1'b0;
        if (cs_lvl) begin
            if (load_strobe) begin
                st_d.dor    = load_data;
                st_d.pend_v = 1'b0;
                upd         = 1'b1;
            end else if (st_q.pend_v) begin
                st_d.dor    = st_q.pend;
                st_d.pend_v = 1'b0;
                upd         = 1'b1;
            end
        end else if (load_strobe) begin
            st_d.pend   = load_data;
            st_d.pend_v = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dor    <= '0;
            st_q.pend   <= '0;
            st_q.pend_v <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    sro_shifter #(.WORD_W(WORD_W)) i_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .word     (st_d.dor),
        .cs_lvl   (cs_lvl),
        .sclk_lvl (sclk_lvl),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    sro_drdy_timer #(.PULSE_W(PULSE_W)) i_drdy (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (upd),
        .rdy_n   (rdy_n)
    );

    // R8: a strobe during a read leaves the output register untouched
    assert_dor_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_lvl && load_strobe) |=> $stable(st_q.dor));

    // R8: once the select is high, a pending word is written on that cycle
    assert_pending_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && st_q.pend_v) |=> !st_q.pend_v);

endmodule

// File: tb/test_ser_readout_port.sv
`timescale 1ns/1ps
module test_ser_readout_port;

    localparam int WORD_W  = 20;
    localparam int PULSE_W = 4;
    localparam int HALF    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WORD_W-1:0] load_data = '0;
    logic              load_strobe = 1'b0;
    logic              sclk_in = 1'b0;
    logic              cs_n_in = 1'b1;
    logic              sdo;
    logic              sdo_oe;
    logic              rdy_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ser_readout_port #(.WORD_W(WORD_W), .PULSE_W(PULSE_W)) i_ser_readout_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_data   (load_data),
        .load_strobe (load_strobe),
        .sclk_in     (sclk_in),
        .cs_n_in     (cs_n_in),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe),
        .rdy_n       (rdy_n)
    );

    function automatic logic exp_bit(input logic [WORD_W-1:0] w, input int k);
        return (k < WORD_W) ? w[WORD_W-1-k] : 1'b0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic idle_sclk(input int periods);
        for (int p = 0; p < periods; p++) begin
            sclk_in = 1'b1; wait_clks(HALF);
            sclk_in = 1'b0; wait_clks(HALF);
        end
    endtask

    // R2 and R3: write a word while idle and measure the ready pulse
    task automatic load_word(input logic [WORD_W-1:0] w);
        int lows;
        load_data   = w;
        load_strobe = 1'b1;
        wait_clks(1);
        load_strobe = 1'b0;
        lows = 0;
        for (int i = 0; i < 2 * PULSE_W; i++) begin
            if (rdy_n === 1'b0) lows++;
            wait_clks(1);
        end
        check("R3 ready pulse width", lows, PULSE_W);
        check("R3 ready high after pulse", rdy_n, 1'b1);
    endtask

    // one read of len bits; optional strobe after bit mid_k
    task automatic do_read(input logic [WORD_W-1:0] w, input int len,
                           input int mid_k, input logic [WORD_W-1:0] mid_w,
                           input int exp_lows);
        int lows;
        cs_n_in = 1'b0;
        wait_clks(HALF);
        check("R4 output enabled", sdo_oe, 1'b1);
        check("R4 first bit is bit 19", sdo, w[WORD_W-1]);
        for (int k = 1; k < len; k++) begin
            sclk_in = 1'b1; wait_clks(HALF);
            if (k > 1) check("R5 stable while serial clock high", sdo, exp_bit(w, k - 1));
            sclk_in = 1'b0; wait_clks(HALF);
            if (k < WORD_W) check("R5 bit order", sdo, exp_bit(w, k));
            else            check("R6 zero padding", sdo, 1'b0);
            if (mid_k > 0 && k > mid_k) check("R8 no ready pulse during read", rdy_n, 1'b1);
            if (k == mid_k) begin
                load_data   = mid_w;
                load_strobe = 1'b1;
                wait_clks(1);
                load_strobe = 1'b0;
                check("R8 no ready pulse at strobe", rdy_n, 1'b1);
            end
        end
        sclk_in = 1'b1; wait_clks(HALF);
        cs_n_in = 1'b1;
        lows = 0;
        for (int i = 0; i < 3 * HALF; i++) begin
            if (rdy_n === 1'b0) lows++;
            wait_clks(1);
        end
        check("R8 ready pulse after select high", lows, exp_lows);
        check("R7 output disabled", sdo_oe, 1'b0);
        sclk_in = 1'b0; wait_clks(HALF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        logic [WORD_W-1:0] w;
        logic [WORD_W-1:0] w2;
        void'($urandom(32'h5EED_1234));
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(2);
        check("R1 ready high after reset", rdy_n, 1'b1);
        check("R1 output disabled after reset", sdo_oe, 1'b0);
        idle_sclk(2);
        do_read('0, 20, 0, '0, 0);

        load_word(20'hFFFFF);
        idle_sclk(1);
        do_read(20'hFFFFF, 24, 0, '0, 0);

        load_word(20'h55555);
        do_read(20'h55555, 20, 0, '0, 0);
        load_word(20'h80000);
        do_read(20'h80000, 24, 0, '0, 0);
        load_word(20'h00001);
        do_read(20'h00001, 22, 0, '0, 0);

        for (int i = 0; i < 8; i++) begin
            w = WORD_W'($urandom);
            load_word(w);
            idle_sclk(i % 3);
            do_read(w, ((i % 2) == 0) ? 20 : 24, 0, '0, 0);
        end

        // R9: a read cut short, then a fresh read from bit 19
        w = 20'hA3C5E;
        load_word(w);
        do_read(w, 6, 0, '0, 0);
        do_read(w, 20, 0, '0, 0);

        // R8: a word loaded during a read is held back until the select rises
        w  = WORD_W'($urandom);
        w2 = ~w;
        load_word(w);
        do_read(w, 20, 5, w2, PULSE_W);
        do_read(w2, 24, 0, '0, 0);

        finish_run();
    end

endmodule